// File: doc/BRIEF.md
# 32-bit Arithmetic Logic Unit with Signed Set-Less-Than

This block is a purely combinational arithmetic logic unit for a simple processor datapath. It takes two 32-bit operands and a 3-bit operation code, and it returns a 32-bit result together with a zero flag and an overflow flag. The zero flag lets branch logic test two operands for equality by subtracting them.

The block supports bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. It is built as a row of identical one-bit slices joined by a ripple carry chain. The top bit of the operation code inverts the second operand and supplies the carry-in, so subtraction uses the same adder as addition.

Set-on-less-than takes the sign of the difference and corrects it with the subtraction overflow. The corrected bit is fed back into bit 0, and every other result bit is cleared. Codes that name no operation produce a zero result.

Top module: `alu32_core`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of the two operands.
- R2: Code 3'b001 gives the bitwise OR of the two operands.
- R3: Code 3'b010 gives the low 32 bits of opnd_a + opnd_b.
- R4: Code 3'b110 gives the low 32 bits of opnd_a - opnd_b, computed as opnd_a + ~opnd_b + 1.
- R5: Code 3'b111 gives 1 in bit 0 when opnd_a is less than opnd_b as two's-complement numbers, and 0 otherwise. Bits 31..1 are always 0. The answer stays correct when the internal subtraction overflows.
- R6: zero_flag is 1 exactly when all 32 result bits are 0, for every code.
- R7: For code 3'b010, ovf_flag is 1 exactly when both operands have the same sign bit and the sign bit of the result differs from it.
- R8: For code 3'b110, ovf_flag is 1 exactly when the operand sign bits differ and the sign bit of the result differs from the sign bit of opnd_a.
- R9: For every code other than 3'b010 and 3'b110, ovf_flag is 0.
- R10: The unused codes 3'b011, 3'b100 and 3'b101 give a result of 0, and therefore a zero_flag of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The bench compares signed operands whose difference overflows, for example the most negative value against a positive number. A design that took the raw sign of the difference would report the wrong ordering for those pairs. It also adds and subtracts across the signed boundary, where swapping the overflow rule for add and subtract, or leaving the flag active for logical codes, makes the flag disagree. The unused codes and the equal-operand subtraction exercise the zero result and the zero flag; a design that left the sum or a logical value on the result for an unused code would be caught there.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // per-slice output select
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

endpackage

// File: rtl/alu32_op_decode.sv
module alu32_op_decode
  import alu32_pkg::*;
(
  input  logic [2:0] op_code,
  output logic [1:0] slice_sel,
  output logic       b_invert,
  output logic       op_legal,
  output logic       ovf_enable
);

  always_comb begin
    slice_sel  = op_code[1:0];
    b_invert   = op_code[2];
    op_legal   = 1'b0;
    ovf_enable = 1'b0;
    case (op_code)
      OP_AND, OP_OR, OP_SLT: op_legal = 1'b1;
      OP_ADD, OP_SUB: begin
        op_legal   = 1'b1;
        ovf_enable = 1'b1;
      end
      default: op_legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu32_bit_slice.sv
module alu32_bit_slice
  import alu32_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       b_invert,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic [1:0] slice_sel,
  output logic       sum_bit,
  output logic       carry_out,
  output logic       res_bit
);

  logic b_eff;

  always_comb begin
    b_eff     = b_bit ^ b_invert;
    sum_bit   = a_bit ^ b_eff ^ carry_in;
    carry_out = (a_bit & b_eff) | (carry_in & (a_bit ^ b_eff));
    case (slice_sel)
      SEL_AND:  res_bit = a_bit & b_eff;
      SEL_OR:   res_bit = a_bit | b_eff;
      SEL_SUM:  res_bit = sum_bit;
      default:  res_bit = less_in;
    endcase
  end

endmodule

// File: rtl/alu32_msb_logic.sv
module alu32_msb_logic (
  input  logic a_sign,
  input  logic b_sign,
  input  logic b_invert,
  input  logic sum_sign,
  output logic ovf_raw,
  output logic set_out
);

  logic b_eff_sign;

  always_comb begin
    b_eff_sign = b_sign ^ b_invert;
    // same effective signs in, different sign out
    ovf_raw    = (a_sign ~^ b_eff_sign) & (sum_sign ^ a_sign);
    // sign of difference corrected by overflow
    set_out    = sum_sign ^ ovf_raw;
  end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag
);

  localparam int MSB = WIDTH - 1;

  logic [1:0]       slice_sel;
  logic             b_invert;
  logic             op_legal;
  logic             ovf_enable;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_vec;
  logic [WIDTH-1:0] slice_res;
  logic             ovf_raw;
  logic             set_bit;

  alu32_op_decode u_dec (
    .op_code    (op_code),
    .slice_sel  (slice_sel),
    .b_invert   (b_invert),
    .op_legal   (op_legal),
    .ovf_enable (ovf_enable)
  );

  assign carry[0] = b_invert;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_i;
    if (i == 0) begin : g_lsb
      assign less_i = set_bit;
    end else begin : g_other
      assign less_i = 1'b0;
    end
    alu32_bit_slice u_slice (
      .a_bit     (opnd_a[i]),
      .b_bit     (opnd_b[i]),
      .b_invert  (b_invert),
      .carry_in  (carry[i]),
      .less_in   (less_i),
      .slice_sel (slice_sel),
      .sum_bit   (sum_vec[i]),
      .carry_out (carry[i+1]),
      .res_bit   (slice_res[i])
    );
  end

  alu32_msb_logic u_msb (
    .a_sign   (opnd_a[MSB]),
    .b_sign   (opnd_b[MSB]),
    .b_invert (b_invert),
    .sum_sign (sum_vec[MSB]),
    .ovf_raw  (ovf_raw),
    .set_out  (set_bit)
  );

  always_comb begin
    result    = op_legal ? slice_res : '0;
    zero_flag = ~|result;
    ovf_flag  = ovf_enable & ovf_raw;
  end

endmodule

// File: rtl/alu32_checker.sv
module alu32_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             ovf_flag
);

  always_comb begin
    AST_AND_SUBSET: assert (op_code != 3'b000 || ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0)); // R1
    AST_OR_COVER: assert (op_code != 3'b001 || ((opnd_a & ~result) == '0 && (opnd_b & ~result) == '0)); // R2
    AST_ADD_INVERSE: assert (op_code != 3'b010 || (result - opnd_b) == opnd_a); // R3
    AST_SUB_INVERSE: assert (op_code != 3'b110 || (result + opnd_b) == opnd_a); // R4
    AST_SLT_UPPER_CLEAR: assert (op_code != 3'b111 || result[WIDTH-1:1] == '0); // R5
    AST_ZERO_FLAG: assert (zero_flag == (result == '0)); // R6
    AST_NO_OVERFLOW: assert (op_code == 3'b010 || op_code == 3'b110 || !ovf_flag); // R9
    AST_UNUSED_ZERO: assert (!(op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101) || zero_flag); // R10
  end

endmodule

bind alu32_core alu32_checker #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_code   (op_code),
  .result    (result),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_alu32_core.sv
`timescale 1ns/1ps
module sim_alu32_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [2:0]  op_code;
  logic [31:0] result;
  logic        zero_flag;
  logic        ovf_flag;

  int n_checks;
  int n_fail;
  int cycles;
  bit done;

  alu32_core u0 (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h op=%b)", tag, act, exp, opnd_a, opnd_b, op_code);
    end
  endtask

  // drive on falling edge, sample a quarter period later
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(negedge clk);
    opnd_a  = a;
    opnd_b  = b;
    op_code = op;
    #(CLK_PERIOD/4);
  endtask

  // expected values from the requirements
  task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [31:0] exp_res;
    logic        exp_ovf;
    logic [32:0] wide;
    apply(a, b, op);
    exp_ovf = 1'b0;
    case (op)
      3'b000: begin exp_res = a & b; check("R1 and", result, exp_res); end
      3'b001: begin exp_res = a | b; check("R2 or", result, exp_res); end
      3'b010: begin
        exp_res = a + b;
        wide = {a[31], a} + {b[31], b};
        exp_ovf = wide[32] ^ wide[31];
        check("R3 add", result, exp_res);
        check("R7 add overflow", {31'd0, ovf_flag}, {31'd0, exp_ovf});
      end
      3'b110: begin
        exp_res = a - b;
        wide = {a[31], a} - {b[31], b};
        exp_ovf = wide[32] ^ wide[31];
        check("R4 sub", result, exp_res);
        check("R8 sub overflow", {31'd0, ovf_flag}, {31'd0, exp_ovf});
      end
      3'b111: begin
        exp_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        check("R5 slt", result, exp_res);
      end
      default: begin exp_res = 32'd0; check("R10 unused code", result, exp_res); end
    endcase
    if (op != 3'b010 && op != 3'b110)
      check("R9 no overflow", {31'd0, ovf_flag}, 32'd0);
    check("R6 zero flag", {31'd0, zero_flag}, {31'd0, (exp_res == 32'd0)});
  endtask

  task automatic t_logic();
    run_vec(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);
    run_vec(32'hAAAA_5555, 32'h5555_AAAA, 3'b000);
    run_vec(32'hF0F0_1234, 32'h0FF0_FF00, 3'b001);
    run_vec(32'h0000_0000, 32'h0000_0000, 3'b001);
  endtask

  task automatic t_add();
    run_vec(32'd5, 32'd7, 3'b010);
    run_vec(32'h7FFF_FFFF, 32'd1, 3'b010);
    run_vec(32'h8000_0000, 32'h8000_0000, 3'b010);
    run_vec(32'hFFFF_FFFF, 32'd1, 3'b010);
    run_vec(32'h8000_0000, 32'h7FFF_FFFF, 3'b010);
  endtask

  task automatic t_sub();
    run_vec(32'd9, 32'd9, 3'b110);
    run_vec(32'd3, 32'd10, 3'b110);
    run_vec(32'h8000_0000, 32'd1, 3'b110);
    run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    run_vec(32'hFFFF_FFFF, 32'h7FFF_FFFF, 3'b110);
  endtask

  task automatic t_slt();
    run_vec(32'd3, 32'd4, 3'b111);
    run_vec(32'd4, 32'd3, 3'b111);
    run_vec(32'd4, 32'd4, 3'b111);
    run_vec(32'hFFFF_FFFF, 32'd0, 3'b111);
    run_vec(32'h8000_0000, 32'd1, 3'b111);
    run_vec(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    run_vec(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
  endtask

  task automatic t_unused();
    run_vec(32'h1234_5678, 32'h0F0F_0F0F, 3'b011);
    run_vec(32'h7FFF_FFFF, 32'd1, 3'b100);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b101);
  endtask

  task automatic t_sweep();
    logic [31:0] lfsr_a;
    logic [31:0] lfsr_b;
    lfsr_a = 32'hACE1_2468;
    lfsr_b = 32'h1357_9BDF;
    for (int i = 0; i < 200; i++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      run_vec(lfsr_a, lfsr_b, 3'(i % 8));
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > WATCHDOG_CYCLES) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG_CYCLES);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    opnd_a   = '0;
    opnd_b   = '0;
    op_code  = 3'b000;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands, AND code
    @(negedge clk);
    check("R6 idle zero flag", {31'd0, zero_flag}, 32'd1);
    check("R1 idle result", result, 32'd0);
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule